// File: doc/BRIEF.md
# Parity-Predicted Integer ALU

A 32-bit arithmetic/logic unit that performs addition, subtraction, AND, OR and XOR, with a concurrent error checker beside it. The checker does not duplicate the datapath. A separate predictor sees only the operands and the opcode, and it works out the parity that each byte of the result ought to have. For addition and subtraction the predictor runs its own ripple carry chain, and it uses the rule that a sum byte's parity is the XOR of the parities of the two operand bytes and of the carries into each bit of that byte. For XOR it combines the operand byte parities. For AND and OR it recomputes a narrow copy of each byte and takes that copy's parity.

The result is registered together with the predicted parities. In the next cycle a checker takes the parity of each byte of the registered result and compares it with the prediction, and a registered flag for each byte records any mismatch. A fault-injection mask is XORed into the ALU result before it is registered, so tests can corrupt chosen bits. A flip of an odd number of bits within a byte is caught. A flip of an even number of bits within a byte is a known blind spot and goes unflagged.

Top module: `alu_pp_top`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `res_o`, `carry_o`, `res_vld_o`, `par_o`, `err_byte_o` and `err_o` are all zero.
- R2: Opcode 3'd0 (ADD). With `valid_i` high, the cycle after the edge that samples it shows `res_o` = (a+b) mod 2^32 and `carry_o` = bit 32 of the sum.
- R3: Opcode 3'd1 (SUB). The result is a + ~b + 1 modulo 2^32, and `carry_o` is bit 32 of that sum, so it is 1 when a >= b unsigned (no borrow).
- R4: Opcodes 3'd2, 3'd3 and 3'd4 give a&b, a|b and a^b respectively, each with `carry_o` = 0.
- R5: Opcodes 3'd5 to 3'd7 give a result of zero, `carry_o` = 0 and a predicted parity of zero.
- R6: `par_o[k]` is the XOR of bits 8k+7..8k of `res_o`, so it is 1 when the byte holds an odd number of ones. It changes together with `res_o`.
- R7: With a zero fault mask, `err_byte_o` and `err_o` stay zero for every opcode and operand.
- R8: If `fault_i` flips an odd number of bits in byte k, `err_byte_o[k]` is 1 exactly one cycle after the corrupted result appears on `res_o`.
- R9: If `fault_i` flips an even number of bits in byte k, `err_byte_o[k]` stays 0 even though `res_o` is wrong.
- R10: When `valid_i` is low, the next cycle has `res_vld_o` = 0 while `res_o` and `carry_o` hold their values, and the cycle after that has `err_byte_o` = 0.
- R11: `err_o` is 1 exactly when some bit of `err_byte_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation request |
| op_i | input | 3 | Opcode: 0 add, 1 sub, 2 and, 3 or, 4 xor |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| fault_i | input | 32 | Mask XORed into the ALU result |
| res_o | output | 32 | Registered result |
| carry_o | output | 1 | Carry out of add/sub |
| res_vld_o | output | 1 | Result is new this cycle |
| par_o | output | 4 | Parity of each result byte |
| err_byte_o | output | 4 | Per-byte parity mismatch, one cycle after the result |
| err_o | output | 1 | Any byte mismatched |

## Verification
The result, the carry, the valid and the byte parity are due at the first falling edge after the rising edge that samples `valid_i`. The mismatch flags for the same operation are due one falling edge later. The bench drives a new operation at every falling edge and keeps a two-stage queue of expected values. At each falling edge it compares the result fields against the latest operation and the error fields against the operation before that, so back-to-back traffic is checked at the exact cycle each output is due.

// File: rtl/alu_pp_pkg.sv
package alu_pp_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = 8;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    // true for operations that go through the carry chain
    function automatic logic op_is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    // true when the second operand must be inverted with carry-in set
    function automatic logic op_is_sub(input alu_op_e op);
        return op == OP_SUB;
    endfunction

endpackage

// File: rtl/alu_pp_core.sv
module alu_pp_core
    import alu_pp_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);

    logic              sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;

    always_comb begin
        sub   = op_is_sub(op_i);
        b_eff = b_i ^ {DATA_W{sub}};
        sum   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    end

    always_comb begin
        res_o   = '0;
        carry_o = 1'b0;
        case (op_i)
            OP_ADD, OP_SUB: begin
                res_o   = sum[DATA_W-1:0];
                carry_o = sum[DATA_W];
            end
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_pp_predict.sv
module alu_pp_predict
    import alu_pp_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int BYTE_W = LANE_W
) (
    input  logic [DATA_W-1:0]        a_i,
    input  logic [DATA_W-1:0]        b_i,
    input  alu_op_e                  op_i,
    output logic [DATA_W/BYTE_W-1:0] pred_o
);

    localparam int NB = DATA_W / BYTE_W;

    logic              sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] cin_vec;   // carry into each bit, own chain

    always_comb begin
        logic c;
        sub   = op_is_sub(op_i);
        b_eff = b_i ^ {DATA_W{sub}};
        c     = sub;
        for (int i = 0; i < DATA_W; i++) begin
            cin_vec[i] = c;
            c = (a_i[i] & b_eff[i]) | ((a_i[i] ^ b_eff[i]) & c);
        end
    end

    for (genvar k = 0; k < NB; k++) begin : g_lane
        logic [BYTE_W-1:0] a_l, b_l, be_l, c_l;
        logic              pa, pb, pbe, pc;

        always_comb begin
            a_l  = a_i[k*BYTE_W +: BYTE_W];
            b_l  = b_i[k*BYTE_W +: BYTE_W];
            be_l = b_eff[k*BYTE_W +: BYTE_W];
            c_l  = cin_vec[k*BYTE_W +: BYTE_W];
            pa   = ^a_l;
            pb   = ^b_l;
            pbe  = ^be_l;
            pc   = ^c_l;
        end

        always_comb begin
            case (op_i)
                OP_ADD, OP_SUB: pred_o[k] = pa ^ pbe ^ pc;
                OP_XOR:         pred_o[k] = pa ^ pb;
                OP_AND:         pred_o[k] = ^(a_l & b_l);
                OP_OR:          pred_o[k] = ^(a_l | b_l);
                default:        pred_o[k] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/alu_pp_check.sv
module alu_pp_check #(
    parameter int DATA_W = alu_pp_pkg::WORD_W,
    parameter int BYTE_W = alu_pp_pkg::LANE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld_i,
    input  logic [DATA_W-1:0]        res_i,
    input  logic [DATA_W/BYTE_W-1:0] pred_i,
    output logic [DATA_W/BYTE_W-1:0] par_o,
    output logic [DATA_W/BYTE_W-1:0] err_byte_o,
    output logic                     err_o
);

    localparam int NB = DATA_W / BYTE_W;

    logic [NB-1:0] diff;

    for (genvar k = 0; k < NB; k++) begin : g_par
        assign par_o[k] = ^res_i[k*BYTE_W +: BYTE_W];
    end

    assign diff = par_o ^ pred_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_byte_o <= '0;
            err_o      <= 1'b0;
        end else begin
            err_byte_o <= vld_i ? diff : '0;
            err_o      <= vld_i && (diff != '0);
        end
    end

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        err_o == (err_byte_o != '0)); // R11

endmodule

// File: rtl/alu_pp_top.sv
module alu_pp_top
    import alu_pp_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int BYTE_W = LANE_W,
    parameter int OP_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     valid_i,
    input  logic [OP_W-1:0]          op_i,
    input  logic [DATA_W-1:0]        a_i,
    input  logic [DATA_W-1:0]        b_i,
    input  logic [DATA_W-1:0]        fault_i,
    output logic [DATA_W-1:0]        res_o,
    output logic                     carry_o,
    output logic                     res_vld_o,
    output logic [DATA_W/BYTE_W-1:0] par_o,
    output logic [DATA_W/BYTE_W-1:0] err_byte_o,
    output logic                     err_o
);

    localparam int NB = DATA_W / BYTE_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              carry;
        logic [NB-1:0]     pred;
        logic              vld;
    } stage_t;

    alu_op_e           op;
    logic [DATA_W-1:0] alu_res;
    logic              alu_carry;
    logic [NB-1:0]     pred;
    stage_t            st_q;

    assign op = alu_op_e'(op_i);

    alu_pp_core #(.DATA_W(DATA_W)) u_core (
        .a_i    (a_i),
        .b_i    (b_i),
        .op_i   (op),
        .res_o  (alu_res),
        .carry_o(alu_carry)
    );

    alu_pp_predict #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pred (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op),
        .pred_o(pred)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.vld <= valid_i;
            if (valid_i) begin
                st_q.res   <= alu_res ^ fault_i;
                st_q.carry <= alu_carry;
                st_q.pred  <= pred;
            end
        end
    end

    alu_pp_check #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
        .clk       (clk),
        .rst       (rst),
        .vld_i     (st_q.vld),
        .res_i     (st_q.res),
        .pred_i    (st_q.pred),
        .par_o     (par_o),
        .err_byte_o(err_byte_o),
        .err_o     (err_o)
    );

    assign res_o     = st_q.res;
    assign carry_o   = st_q.carry;
    assign res_vld_o = st_q.vld;

    AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !res_vld_o); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(res_o) && $stable(carry_o))); // R10
    AST_CLEAN_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (valid_i && fault_i == '0) |=> ##1 !err_o); // R7
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i > OP_W'(4) && fault_i == '0) |=> (res_o == '0 && !carry_o)); // R5

    for (genvar k = 0; k < NB; k++) begin : g_ast
        AST_ODD_FLIP_FLAG: assert property (@(posedge clk) disable iff (rst)
            (valid_i && ^fault_i[k*BYTE_W +: BYTE_W]) |=> ##1 err_byte_o[k]); // R8
        AST_EVEN_FLIP_BLIND: assert property (@(posedge clk) disable iff (rst)
            (valid_i && !(^fault_i[k*BYTE_W +: BYTE_W])) |=> ##1 !err_byte_o[k]); // R9
    end

endmodule

// File: tb/alu_pp_top_tb.sv
`timescale 1ns/1ps
module alu_pp_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [31:0] a_i = '0, b_i = '0, fault_i = '0;
    logic [31:0] res_o;
    logic        carry_o, res_vld_o, err_o;
    logic [3:0]  par_o, err_byte_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] e_res = '0;
    logic        e_carry = 1'b0;
    logic [3:0]  pend_err = '0;
    string       pend_tag = "R7";

    always #2 clk = ~clk;

    alu_pp_top dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .fault_i(fault_i),
        .res_o(res_o), .carry_o(carry_o), .res_vld_o(res_vld_o),
        .par_o(par_o), .err_byte_o(err_byte_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] bpar(input logic [31:0] v);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) p[k] = ^v[k*8 +: 8];
        return p;
    endfunction

    function automatic logic [32:0] ref_alu(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b);
        case (op)
            3'd0:    return {1'b0, a} + {1'b0, b};
            3'd1:    return {1'b0, a} + {1'b0, ~b} + 33'd1;
            3'd2:    return {1'b0, a & b};
            3'd3:    return {1'b0, a | b};
            3'd4:    return {1'b0, a ^ b};
            default: return 33'd0;
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0:    return "R2";
            3'd1:    return "R3";
            3'd2, 3'd3, 3'd4: return "R4";
            default: return "R5";
        endcase
    endfunction

    // drive at a falling edge, check at the next falling edge
    task automatic step(input logic v, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] m);
        logic [32:0] r;
        string       tag;
        valid_i = v; op_i = op; a_i = a; b_i = b; fault_i = m;
        @(negedge clk);
        tag = v ? op_tag(op) : "R10";
        if (v) begin
            r       = ref_alu(op, a, b);
            e_res   = r[31:0] ^ m;
            e_carry = r[32];
        end
        chk(tag, res_o, e_res);
        chk(tag, {31'd0, carry_o}, {31'd0, e_carry});
        chk("R10", {31'd0, res_vld_o}, {31'd0, v});
        chk("R6", {28'd0, par_o}, {28'd0, bpar(e_res)});
        chk(pend_tag, {28'd0, err_byte_o}, {28'd0, pend_err});
        chk("R11", {31'd0, err_o}, {31'd0, pend_err != 4'd0});
        pend_err = v ? bpar(m) : 4'd0;
        if (!v)             pend_tag = "R10";
        else if (m == '0)   pend_tag = "R7";
        else if (bpar(m) != 4'd0) pend_tag = "R8";
        else                pend_tag = "R9";
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        chk("R1", res_o, 32'd0);
        chk("R1", {27'd0, carry_o, res_vld_o, err_o, 2'd0}, 32'd0);
        chk("R1", {24'd0, par_o, err_byte_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {27'd0, res_vld_o, err_byte_o}, 32'd0);

        step(1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 0);   // R2 wrap with carry
        step(1, 3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 0);   // R2 carry through all bytes
        step(1, 3'd1, 32'd5, 32'd7, 0);                   // R3 borrow
        step(1, 3'd1, 32'd7, 32'd5, 0);                   // R3 no borrow
        step(1, 3'd1, 32'd0, 32'd0, 0);                   // R3 zero minus zero
        step(1, 3'd2, 32'hF0F0_1234, 32'hFF00_00FF, 0);   // R4 and
        step(1, 3'd3, 32'hF0F0_1234, 32'h0F00_00FF, 0);   // R4 or
        step(1, 3'd4, 32'hA5A5_A5A5, 32'h5A5A_0FF0, 0);   // R4 xor
        step(1, 3'd5, 32'h1234_5678, 32'h9ABC_DEF0, 0);   // R5
        step(1, 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);   // R5
        step(1, 3'd0, 32'h0101_0101, 32'h0303_0303, 0);
        step(0, 3'd1, 32'hDEAD_BEEF, 32'h1, 32'hFF);      // R10 idle: hold, no flag
        step(0, 3'd0, 32'h0, 32'h0, 0);                   // R10
        step(1, 3'd0, 32'h1111_1111, 32'h2222_2222, 32'h0000_0001); // R8 byte0
        step(1, 3'd1, 32'h8000_0000, 32'h1, 32'h8100_0000);         // R9 byte3 even
        step(1, 3'd3, 32'h0, 32'h0, 32'h0003_0080);       // R8 byte0, R9 byte2
        step(1, 3'd2, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF); // R9 all bytes even
        step(1, 3'd4, 32'h0, 32'h0, 32'h0107_0F1F);       // R8 byte3,2,0 odd

        for (int i = 0; i < 400; i++) begin
            logic [31:0] m;
            m = ($urandom % 4 == 0) ? $urandom : 32'd0;
            step(($urandom % 8) != 0, 3'($urandom % 8), $urandom, $urandom, m);
        end
        step(0, 3'd0, 0, 0, 0);
        step(0, 3'd0, 0, 0, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule